// File: doc/BRIEF.md
# Dual Down-Counter Timer with Latched Byte Readback

The block holds two independent down-counters, a wide one for counter 0 (24 bits by default) and a narrower one for counter 1 (16 bits by default). A host reaches them through a small byte-wide register port. Three data addresses form a staging register for load values. A fourth address takes command bytes. In each command byte the top bit picks a counter and the low three bits pick an action.

Each counter has its own count-clock input, sampled as a one-cycle tick in the system clock domain, and a gate input. It counts down by one on every qualified tick. When its next tick would bring it to zero, it reloads from its reload register. Its output then stays high for exactly one count-clock period, until that counter's next tick.

Reads of the data addresses never return the live count or the staged value. They return a snapshot that the last latch command captured. Because the bus is a plain register port with no flow control, every write takes effect in the cycle it is presented, and reads are combinational from the snapshot.

Top module: `ct_latched_timer`

## Requirements
- R1: After reset both counters are zero, disabled and ungated, both outputs are low, and every data address reads 0x00.
- R2: Writes to address 0, 1 and 2 set the low, middle and high byte of the staging register. A load command (code 2) copies the staging value into the selected counter's count and reload registers and drives its output low. Counter 1 takes only the low 16 bits.
- R3: Bit 7 of a command byte selects the counter (0 selects counter 0, 1 selects counter 1). A command never affects the other counter.
- R4: Code 3 enables counting and code 4 disables it. An enabled counter decrements by one on each qualified tick, and a disabled counter holds its count.
- R5: Code 5 turns gating on and code 6 turns it off. With gating on, a tick is qualified only while that counter's gate input is high. With gating off, the gate input is ignored.
- R6: On a qualified tick, a count of 1 or 0 reloads from the reload register and sets the output high. Any other count decrements and sets the output low. Any unqualified tick sets the output low. Between ticks the output holds, so a pulse lasts one count-clock period.
- R7: Code 7 captures the selected counter's current count, taken before that cycle's step, into a snapshot. Data addresses 0, 1 and 2 read the snapshot's low, middle and high bytes. Later counting and staging writes leave the readback unchanged.
- R8: Code 1 clears the selected counter's count to zero and drives its output low. The command bytes for this are 0x01 for counter 0 and 0x81 for counter 1.
- R9: Only bits 2:0 form the action code, and command bits 6:3 are ignored. Code 0 does nothing.
- R10: The bytes of a snapshot above a counter's width read as zero, so a counter 1 snapshot has high byte 0x00. Address 3 always reads 0x00.
- R11: A load or clear in the same cycle as a tick overrides that tick. Enable and gate changes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0..2 staging bytes, 3 command |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Snapshot byte at rd_addr (combinational) |
| cnt_tick_i | input | 2 | Per-counter count-clock tick, bit n for counter n |
| cnt_gate_i | input | 2 | Per-counter gate, bit n for counter n |
| cnt_out_o | output | 2 | Per-counter terminal output, bit n for counter n |

## Verification
The bench builds the block with the default widths of 24 and 16 bits. It loads small values, so that reload and pulse windows arrive within a few ticks. It also loads a full three-byte pattern to show counter 1 truncation and the zero high byte of its snapshot. A behavioural model steps both counters on every clock and is compared against the outputs and readback every cycle. The stimulus covers:
- gated and ungated tick patterns;
- load and clear colliding with ticks;
- command bytes with junk in bits 6:3.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_CLEAR    = 3'd1,
    CMD_LOAD     = 3'd2,
    CMD_RUN      = 3'd3,
    CMD_HALT     = 3'd4,
    CMD_GATE_ON  = 3'd5,
    CMD_GATE_OFF = 3'd6,
    CMD_LATCH    = 3'd7
  } ct_cmd_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic run;
    logic halt;
    logic gate_on;
    logic gate_off;
  } ct_strobe_t;
endpackage

// File: rtl/ct_cmd_decode.sv
module ct_cmd_decode
  import ct_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CMD_ADDR = 3,
  parameter int NUM_CNT  = 2
) (
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  output ct_strobe_t [NUM_CNT-1:0]  strb_o,
  output logic                      latch_o,
  output logic                      latch_sel_o
);
  logic    cmd_wr;
  ct_cmd_e code;

  assign cmd_wr      = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
  assign code        = ct_cmd_e'(wr_data[2:0]);
  assign latch_o     = cmd_wr && (code == CMD_LATCH);
  assign latch_sel_o = wr_data[7];

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_dec
    logic hit;
    assign hit = cmd_wr && (wr_data[7] == gi[0]);
    assign strb_o[gi].load     = hit && (code == CMD_LOAD);
    assign strb_o[gi].clear    = hit && (code == CMD_CLEAR);
    assign strb_o[gi].run      = hit && (code == CMD_RUN);
    assign strb_o[gi].halt     = hit && (code == CMD_HALT);
    assign strb_o[gi].gate_on  = hit && (code == CMD_GATE_ON);
    assign strb_o[gi].gate_off = hit && (code == CMD_GATE_OFF);
  end
endmodule

// File: rtl/ct_down_counter.sv
module ct_down_counter
  import ct_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  ct_strobe_t   strb,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         gate,
  output logic [W-1:0] count_o,
  output logic         out_o
);
  logic [W-1:0] cnt_q, rel_q;
  logic         en_q, gmode_q, out_q;
  logic         qualified;

  assign qualified = tick && en_q && (!gmode_q || gate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      out_q <= 1'b0;
    end else if (strb.load) begin
      cnt_q <= load_val;
      rel_q <= load_val;
      out_q <= 1'b0;
    end else if (strb.clear) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (tick) begin
      if (qualified && (cnt_q <= W'(1))) begin
        cnt_q <= rel_q;
        out_q <= 1'b1;
      end else if (qualified) begin
        cnt_q <= cnt_q - W'(1);
        out_q <= 1'b0;
      end else begin
        out_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      gmode_q <= 1'b0;
    end else begin
      if (strb.run)       en_q    <= 1'b1;
      else if (strb.halt) en_q    <= 1'b0;
      if (strb.gate_on)       gmode_q <= 1'b1;
      else if (strb.gate_off) gmode_q <= 1'b0;
    end
  end

  assign count_o = cnt_q;
  assign out_o   = out_q;
endmodule

// File: rtl/ct_readback.sv
module ct_readback #(
  parameter int DATA_BYTES = 3,
  parameter int ADDR_W     = 2,
  localparam int SNAP_W    = 8 * DATA_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch,
  input  logic [SNAP_W-1:0] latch_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [SNAP_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     snap_q <= '0;
    else if (latch) snap_q <= latch_val;
  end

  always_comb begin
    rd_data = 8'h00;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (rd_addr == ADDR_W'(b)) rd_data = snap_q[8*b +: 8];
    end
  end
endmodule

// File: rtl/ct_latched_timer.sv
module ct_latched_timer
  import ct_pkg::*;
#(
  parameter int CNT0_W = 24,
  parameter int CNT1_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic [1:0] cnt_tick_i,
  input  logic [1:0] cnt_gate_i,
  output logic [1:0] cnt_out_o
);
  localparam int NUM_CNT    = 2;
  localparam int ADDR_W     = 2;
  localparam int DATA_BYTES = 3;
  localparam int CMD_ADDR   = DATA_BYTES;
  localparam int STAGE_W    = 8 * DATA_BYTES;

  ct_strobe_t [NUM_CNT-1:0] strb;
  logic                     latch, latch_sel;
  logic [STAGE_W-1:0]       stage_q;
  logic [STAGE_W-1:0]       count_ext [NUM_CNT];
  logic [STAGE_W-1:0]       latch_val;

  ct_cmd_decode #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .NUM_CNT(NUM_CNT)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .strb_o(strb), .latch_o(latch), .latch_sel_o(latch_sel)
  );

  for (genvar bi = 0; bi < DATA_BYTES; bi++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[8*bi +: 8] <= 8'h00;
      else if (wr_en && (wr_addr == ADDR_W'(bi))) stage_q[8*bi +: 8] <= wr_data;
    end
  end

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    localparam int W = (gi == 0) ? CNT0_W : CNT1_W;
    logic [W-1:0]       cnt;
    logic [STAGE_W-1:0] ext;

    ct_down_counter #(.W(W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .strb(strb[gi]),
      .load_val(stage_q[W-1:0]),
      .tick(cnt_tick_i[gi]), .gate(cnt_gate_i[gi]),
      .count_o(cnt), .out_o(cnt_out_o[gi])
    );

    always_comb begin
      ext        = '0;
      ext[W-1:0] = cnt;
    end
    assign count_ext[gi] = ext;
  end

  assign latch_val = latch_sel ? count_ext[1] : count_ext[0];

  ct_readback #(.DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W)) u_rb (
    .clk(clk), .rst_n(rst_n), .latch(latch), .latch_val(latch_val),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/ct_latched_timer_chk.sv
module ct_latched_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [1:0] rd_addr,
  input logic [7:0] rd_data,
  input logic [1:0] cnt_tick_i,
  input logic [1:0] cnt_out_o
);
  logic cmd_wr;
  assign cmd_wr = wr_en && (wr_addr == 2'd3);

  AST_OUT0_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick_i[0] && !cmd_wr) |=> $stable(cnt_out_o[0])); // R6
  AST_OUT1_HOLDS_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_tick_i[1] && !cmd_wr) |=> $stable(cnt_out_o[1])); // R6
  AST_SNAPSHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (rd_addr != $past(rd_addr) || $stable(rd_data))); // R7
  AST_CLEAR_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[2:0] == 3'd1 && !wr_data[7]) |=> !cnt_out_o[0]); // R8
  AST_LOAD_DROPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wr_data[2:0] == 3'd2 && wr_data[7]) |=> !cnt_out_o[1]); // R2
  AST_CMD_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (rd_data == 8'h00)); // R10
endmodule

bind ct_latched_timer ct_latched_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .cnt_tick_i(cnt_tick_i), .cnt_out_o(cnt_out_o)
);

// File: tb/ct_latched_timer_bench.sv
`timescale 1ns/1ps
module ct_latched_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] cnt_tick_i = '0;
  logic [1:0] cnt_gate_i = '0;
  logic [1:0] cnt_out_o;

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit done = 0;

  int m_cnt[2], m_rel[2], m_out[2], m_en[2], m_gm[2];
  int m_stage, m_snap;
  int mask[2] = '{32'hFF_FFFF, 32'hFFFF};

  always #2 clk = ~clk;

  ct_latched_timer u_ct_latched_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cnt_tick_i(cnt_tick_i),
    .cnt_gate_i(cnt_gate_i), .cnt_out_o(cnt_out_o)
  );

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 0; m_rel[i] = 0; m_out[i] = 0; m_en[i] = 0; m_gm[i] = 0;
    end
    m_stage = 0; m_snap = 0;
  endtask

  task automatic model_step();
    bit cmd = wr_en && wr_addr == 2'd3;
    int sel = wr_data[7];
    int code = wr_data[2:0];
    if (cmd && code == 7) m_snap = m_cnt[sel];
    for (int i = 0; i < 2; i++) begin
      bit hit = cmd && sel == i;
      if (hit && code == 2) begin
        m_cnt[i] = m_stage & mask[i]; m_rel[i] = m_cnt[i]; m_out[i] = 0;
      end else if (hit && code == 1) begin
        m_cnt[i] = 0; m_out[i] = 0;
      end else if (cnt_tick_i[i]) begin
        if (m_en[i] != 0 && (m_gm[i] == 0 || cnt_gate_i[i])) begin
          if (m_cnt[i] <= 1) begin m_cnt[i] = m_rel[i]; m_out[i] = 1; end
          else begin m_cnt[i] = m_cnt[i] - 1; m_out[i] = 0; end
        end else m_out[i] = 0;
      end
      if (hit && code == 3) m_en[i] = 1;
      if (hit && code == 4) m_en[i] = 0;
      if (hit && code == 5) m_gm[i] = 1;
      if (hit && code == 6) m_gm[i] = 0;
    end
    if (wr_en && wr_addr != 2'd3) begin
      int sh = 8 * int'(wr_addr);
      m_stage = (m_stage & ~(32'hFF << sh)) | (int'(wr_data) << sh);
    end
  endtask

  task automatic compare();
    int exp_rd = (rd_addr == 2'd3) ? 0 : ((m_snap >> (8 * int'(rd_addr))) & 255);
    for (int i = 0; i < 2; i++) begin
      n_chk++;
      if (cnt_out_o[i] !== m_out[i][0]) begin
        n_err++;
        $display("FAIL %s out%0d got %b exp %0d", cur_req, i, cnt_out_o[i], m_out[i]);
      end
    end
    n_chk++;
    if (rd_data !== exp_rd[7:0]) begin
      n_err++;
      $display("FAIL %s rd_data[addr %0d] got %h exp %h", cur_req, rd_addr, rd_data, exp_rd[7:0]);
    end
  endtask

  task automatic step(bit we, logic [1:0] wa, logic [7:0] wd,
                      logic [1:0] tk, logic [1:0] gt, logic [1:0] ra);
    wr_en = we; wr_addr = wa; wr_data = wd;
    cnt_tick_i = tk; cnt_gate_i = gt; rd_addr = ra;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(1'b1, a, d, 2'b00, 2'b00, 2'd0);
  endtask

  task automatic run(int n, logic [1:0] tk, logic [1:0] gt);
    for (int k = 0; k < n; k++) step(1'b0, 2'd0, 8'h00, tk, gt, 2'(k % 4));
  endtask

  task automatic read_all();
    for (int a = 0; a < 4; a++) step(1'b0, 2'd0, 8'h00, 2'b00, 2'b00, 2'(a));
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; read_all();
    cur_req = "R2"; wr(0, 8'h05); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h02);
    cur_req = "R4"; wr(3, 8'h03);
    cur_req = "R6"; run(14, 2'b01, 2'b00);
    run(6, 2'b00, 2'b00);
    cur_req = "R7"; wr(3, 8'h07); run(5, 2'b01, 2'b00); read_all();
    wr(0, 8'hEE); read_all();
    cur_req = "R3"; wr(0, 8'h03); wr(3, 8'h82); wr(3, 8'h83);
    for (int k = 0; k < 12; k++) step(1'b0, 2'd0, 8'h00, 2'(k % 3 == 0 ? 2'b10 : 2'b11), 2'b00, 2'd0);
    cur_req = "R5"; wr(3, 8'h85);
    for (int k = 0; k < 16; k++) step(1'b0, 2'd0, 8'h00, 2'b10, 2'({k[2], 1'b0}), 2'd1);
    wr(3, 8'h86); run(6, 2'b10, 2'b00);
    cur_req = "R10"; wr(0, 8'h56); wr(1, 8'h34); wr(2, 8'h12); wr(3, 8'h82);
    wr(3, 8'h87); read_all();
    cur_req = "R2"; wr(3, 8'h02); wr(3, 8'h07); read_all();
    cur_req = "R8"; wr(0, 8'h04); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h02);
    run(3, 2'b01, 2'b00); wr(3, 8'h01); wr(3, 8'h07); read_all(); run(7, 2'b01, 2'b00);
    wr(3, 8'h81); wr(3, 8'h87); read_all();
    cur_req = "R9"; run(2, 2'b01, 2'b00); wr(3, 8'h79); wr(3, 8'h7F); read_all();
    wr(3, 8'h78); run(4, 2'b01, 2'b00); wr(3, 8'h47); read_all();
    cur_req = "R11";
    step(1'b1, 2'd3, 8'h02, 2'b11, 2'b00, 2'd0);
    step(1'b1, 2'd3, 8'h81, 2'b11, 2'b00, 2'd0);
    step(1'b1, 2'd3, 8'h04, 2'b11, 2'b00, 2'd0);
    run(4, 2'b11, 2'b00);
    step(1'b1, 2'd3, 8'h03, 2'b01, 2'b00, 2'd0);
    run(5, 2'b01, 2'b00);
    cur_req = "R4"; wr(3, 8'h04); run(5, 2'b01, 2'b00); wr(3, 8'h07); read_all();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog %s got hang exp completion", cur_req);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule